// File: doc/BRIEF.md
# Clocked Serial Shift Interface

This block moves one byte at a time over a three-wire synchronous link (shift clock, serial out, serial in). It is meant for a small 4-bit controller. The CPU sees the 8-bit shift register as two 4-bit halves with separate write strobes. It programs a 4-bit write-only mode word and issues a start command. When the transfer ends, the block raises a sticky interrupt flag. The shift clock comes either from an internal power-of-two divider of the CPU clock or from an external clock pin.

A start command takes the unit from idle into a wait state. The unit enters the transfer state once the shift clock is high. Bits leave least significant first on each falling shift-clock edge and are captured on each rising edge. After eight rising edges the unit returns to idle and raises the flag. Writing the mode word re-initializes the unit at once: any transfer in progress is abandoned and the bit counter is cleared. The newly written mode itself reaches the clock logic one cycle later than the write.

Top module: `sio_shift_unit`

## Requirements
- R1: After a synchronous reset the outputs are as follows: `irq_flag` is 0, `sck_oe` is 0, `sck_out` is 1, `so` is 1, and both data halves read 0.
- R2: The mode word has these fields:
    - bit 0 enables the clock pin for serial use;
    - bit 1 selects the internal clock (1) or the external clock (0);
    - bits 3:2 give `r`, so that the internal shift clock's half period is 2^(PRE_BASE+r) CPU cycles.

  `sck_oe` equals bit0 AND bit1. The internal shift clock idles high.
- R3: A mode write sampled at edge k shows in `sck_oe` after edge k+1 and not after edge k.
- R4: With the internal clock and half period H, `irq_flag` is still 0 after edge 16H+1 and becomes 1 at edge 16H+2, where the edge that samples `start_cmd` in idle is edge 0.
- R5: `so` takes the next bit, least significant first, on a falling shift-clock edge. `si` is shifted in on a rising edge from the top. After eight rising edges the data halves hold the received byte.
- R6: With bit0=1 and bit1=0, shifting follows `sck_in`. With bit0=0 in external mode, `sck_in` toggles cause no shifting and no completion.
- R7: A mode write while transferring aborts to idle, clears the bit counter and sets `irq_flag` at that edge. The next start then runs a full eight-bit transfer with the R4 timing.
- R8: An abort taken while zero bits have been received and the shift clock is low (the first low phase) leaves `irq_flag` at 0.
- R9: A start command while transferring (outside the first low phase) sets `irq_flag` and restarts the transfer through the wait state. The restarted transfer completes on the R4 timing.
- R10: `irq_flag` stays set until `flag_clr` is sampled high. A completion in the same cycle as `flag_clr` leaves it set.
- R11: `stop_enter` clears the mode word at the next edge (`sck_oe` goes to 0) and returns the unit to idle without setting `irq_flag`.
- R12: `dlo_wr` writes bits 3:0 and `dhi_wr` writes bits 7:4 from `data_wdata`. Both writes are ignored while transferring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_enter | input | 1 | Stop-mode entry pulse; clears the mode word |
| mode_wr | input | 1 | Mode word write strobe |
| mode_wdata | input | 4 | Mode word value |
| start_cmd | input | 1 | Start transfer command |
| dlo_wr | input | 1 | Write strobe for data bits 3:0 |
| dhi_wr | input | 1 | Write strobe for data bits 7:4 |
| data_wdata | input | 4 | Nibble written by the data strobes |
| data_lo | output | 4 | Shift register bits 3:0 |
| data_hi | output | 4 | Shift register bits 7:4 |
| flag_clr | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Sticky transfer-end interrupt flag |
| sck_in | input | 1 | External shift clock from the pin |
| sck_out | output | 1 | Internal shift clock to the pin |
| sck_oe | output | 1 | Drive enable for the clock pin |
| so | output | 1 | Serial data out |
| si | input | 1 | Serial data in |

## Verification
Results fall due at fixed latencies:
- The mode word reaches `sck_oe` at the second edge after the write.
- An abort or a restart sets the flag at the very edge that samples the command.
- An internal-clock transfer raises the flag at exactly edge 16H+2.

For each of these, the bench steps a counted number of full cycles and samples at the falling CPU clock edge. It checks one cycle before and at the due edge. External-clock activity passes through a synchronizer and an edge detector, so it settles within two CPU cycles. The bench holds each `sck_in` phase for four cycles before sampling `so` or the flag.

// File: rtl/sio_pkg.sv
// Shared types for the serial shift interface.
package sio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2
    } sio_state_e;

    // Mode word layout: [3:2] ratio, [1] internal source, [0] pin enable.
    typedef struct packed {
        logic [1:0] ratio;
        logic       int_src;
        logic       pin_en;
    } sio_mode_t;
endpackage

// File: rtl/sio_mode_reg.sv
// Mode word holder. A write lands in a pending stage and reaches the active
// copy one edge later, so it takes effect from the second cycle on.
// Assumes stop_enter and reset both clear the word to zero.
module sio_mode_reg
    import sio_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stop_enter,
    input  logic      wr,
    input  sio_mode_t wdata,
    output sio_mode_t active
);
    sio_mode_t pend_q;
    sio_mode_t act_q;
    logic      pend_vld_q;

    // Two-stage pipeline from write strobe to active mode.
    always_ff @(posedge clk) begin
        if (!rst_n || stop_enter) begin
            pend_q     <= '0;
            act_q      <= '0;
            pend_vld_q <= 1'b0;
        end else begin
            pend_vld_q <= wr;
            if (wr)         pend_q <= wdata;
            if (pend_vld_q) act_q  <= pend_q;
        end
    end

    assign active = act_q;

    // R3: an isolated write does not alter the active mode at its own edge.
    assert_mode_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !$past(wr) && !stop_enter && !$past(stop_enter)) |=> $stable(act_q));
endmodule

// File: rtl/sio_clkgen.sv
// Shift clock source. Divides the CPU clock by a power of two while the
// internal source is running, or synchronizes the external pin. It also
// produces one-cycle fall and rise pulses of the selected clock level.
// Assumes sck_in changes far slower than clk.
module sio_clkgen
    import sio_pkg::*;
#(
    parameter int PRE_BASE = 1,
    parameter int RATIO_W  = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  sio_mode_t mode,
    input  logic      sck_in,
    output logic      sck_int,
    output logic      sck_lvl,
    output logic      fall,
    output logic      rise
);
    localparam int MAX_SH = PRE_BASE + (1 << RATIO_W) - 1;
    localparam int CNT_W  = MAX_SH + 1;

    logic [CNT_W-1:0] div_q;
    logic [CNT_W-1:0] half_m1;
    logic             sck_int_q;
    logic             sync_q;
    logic             prev_q;
    logic             run_int;

    assign run_int = run && mode.int_src;
    assign half_m1 = CNT_W'((1 << (PRE_BASE + int'(mode.ratio))) - 1);

    // Internal divider: toggles the clock every half period, idles high.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_int) begin
            div_q     <= '0;
            sck_int_q <= 1'b1;
        end else if (div_q == half_m1) begin
            div_q     <= '0;
            sck_int_q <= ~sck_int_q;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // External pin synchronizer and previous-level register for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= sck_in;
            prev_q <= sck_lvl;
        end
    end

    assign sck_int = sck_int_q;
    assign sck_lvl = mode.int_src ? sck_int_q : (mode.pin_en ? sync_q : 1'b1);
    assign fall    = prev_q && !sck_lvl;
    assign rise    = !prev_q && sck_lvl;

    // R2: the internal clock is high in any cycle after it was stopped.
    assert_clk_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_int |=> sck_int_q);
endmodule

// File: rtl/sio_shift_core.sv
// Transfer control: idle/wait/transfer states, octal bit counter, shift
// register, serial output latch and sticky interrupt flag. Assumes fall and
// rise are single-cycle pulses of the selected shift clock.
module sio_shift_core
    import sio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_enter,
    input  logic              mode_wr,
    input  logic              start_cmd,
    input  logic              dlo_wr,
    input  logic              dhi_wr,
    input  logic [DATA_W/2-1:0] wdata,
    input  logic              flag_clr,
    input  logic              sck_lvl,
    input  logic              fall,
    input  logic              rise,
    input  logic              si,
    output logic              run,
    output logic [DATA_W-1:0] sr,
    output logic              so,
    output logic              irq
);
    localparam int NIB_W = DATA_W / 2;
    localparam int CNT_W = $clog2(DATA_W);

    sio_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DATA_W-1:0] sr_q;
    logic             so_q;
    logic             irq_q;
    logic             xfer;
    logic             first_low;
    logic             abort;
    logic             done;

    assign xfer      = (state_q == ST_XFER);
    assign first_low = xfer && (cnt_q == '0) && !sck_lvl;
    assign abort     = xfer && (mode_wr || start_cmd);
    assign done      = xfer && rise && !abort && (cnt_q == CNT_W'(DATA_W - 1));

    // State sequencing: mode write or stop re-initializes, start re-arms.
    always_ff @(posedge clk) begin
        if (!rst_n || stop_enter || mode_wr) begin
            state_q <= ST_IDLE;
        end else if (start_cmd) begin
            state_q <= ST_WAIT;
        end else begin
            case (state_q)
                ST_WAIT: if (sck_lvl) state_q <= ST_XFER;
                ST_XFER: if (done)    state_q <= ST_IDLE;
                default: state_q <= state_q;
            endcase
        end
    end

    // Octal bit counter: counts rising edges, cleared outside transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || stop_enter || mode_wr || start_cmd || !xfer) begin
            cnt_q <= '0;
        end else if (rise) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Shift register: shifts in on rise during transfer, nibble writes otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (xfer) begin
            if (rise && !abort && !stop_enter) sr_q <= {si, sr_q[DATA_W-1:1]};
        end else begin
            if (dlo_wr) sr_q[NIB_W-1:0]      <= wdata;
            if (dhi_wr) sr_q[DATA_W-1:NIB_W] <= wdata;
        end
    end

    // Serial output latch: presents the next low bit on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            so_q <= 1'b1;
        end else if (xfer && fall && !abort && !stop_enter) begin
            so_q <= sr_q[0];
        end
    end

    // Sticky interrupt flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (done || (abort && !first_low && !stop_enter)) begin
            irq_q <= 1'b1;
        end else if (flag_clr) begin
            irq_q <= 1'b0;
        end
    end

    assign run = xfer;
    assign sr  = sr_q;
    assign so  = so_q;
    assign irq = irq_q;

    // R7: the bit counter is zero whenever no transfer is running.
    assert_cnt_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_XFER) |-> (cnt_q == '0));
    // R7: an abort outside the first low phase raises the flag.
    assert_abort_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !first_low && !stop_enter) |=> irq_q);
    // R8: an abort in the first low phase does not raise the flag.
    assert_first_low_noflag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (first_low && mode_wr && !irq_q) |=> !irq_q);
    // R10: the flag only rises out of the transfer state.
    assert_flag_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(state_q == ST_XFER));
    // R12: outside transfer the data only changes through a nibble write.
    assert_sr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_XFER && !dlo_wr && !dhi_wr) |=> $stable(sr_q));
endmodule

// File: rtl/sio_shift_unit.sv
// Top of the serial shift interface: mode word, shift clock source and
// transfer core. Assumes single-cycle CPU strobes and an 8-bit data path.
module sio_shift_unit
    import sio_pkg::*;
#(
    parameter int PRE_BASE = 1,
    parameter int DATA_W   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_enter,
    input  logic       mode_wr,
    input  logic [3:0] mode_wdata,
    input  logic       start_cmd,
    input  logic       dlo_wr,
    input  logic       dhi_wr,
    input  logic [3:0] data_wdata,
    output logic [3:0] data_lo,
    output logic [3:0] data_hi,
    input  logic       flag_clr,
    output logic       irq_flag,
    input  logic       sck_in,
    output logic       sck_out,
    output logic       sck_oe,
    output logic       so,
    input  logic       si
);
    sio_mode_t         mode_act;
    logic              run;
    logic              sck_lvl;
    logic              fall;
    logic              rise;
    logic [DATA_W-1:0] sr;

    sio_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_enter (stop_enter),
        .wr         (mode_wr),
        .wdata      (sio_mode_t'(mode_wdata)),
        .active     (mode_act)
    );

    sio_clkgen #(.PRE_BASE(PRE_BASE)) u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .mode    (mode_act),
        .sck_in  (sck_in),
        .sck_int (sck_out),
        .sck_lvl (sck_lvl),
        .fall    (fall),
        .rise    (rise)
    );

    sio_shift_core #(.DATA_W(DATA_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_enter (stop_enter),
        .mode_wr    (mode_wr),
        .start_cmd  (start_cmd),
        .dlo_wr     (dlo_wr),
        .dhi_wr     (dhi_wr),
        .wdata      (data_wdata),
        .flag_clr   (flag_clr),
        .sck_lvl    (sck_lvl),
        .fall       (fall),
        .rise       (rise),
        .si         (si),
        .run        (run),
        .sr         (sr),
        .so         (so),
        .irq        (irq_flag)
    );

    assign sck_oe  = mode_act.pin_en && mode_act.int_src;
    assign data_lo = sr[3:0];
    assign data_hi = sr[7:4];
endmodule

// File: tb/sio_shift_unit_bench.sv
module sio_shift_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n, stop_enter, mode_wr, start_cmd, dlo_wr, dhi_wr, flag_clr;
    logic [3:0] mode_wdata, data_wdata, data_lo, data_hi;
    logic       irq_flag, sck_in, sck_out, sck_oe, so, si;
    logic       loop_en, si_drv;
    int         n_tests = 0;
    int         n_fail  = 0;
    bit         finished = 1'b0;

    always #10 clk = ~clk;
    assign si = loop_en ? so : si_drv;

    sio_shift_unit u_sio_shift_unit (
        .clk(clk), .rst_n(rst_n), .stop_enter(stop_enter), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .start_cmd(start_cmd), .dlo_wr(dlo_wr),
        .dhi_wr(dhi_wr), .data_wdata(data_wdata), .data_lo(data_lo),
        .data_hi(data_hi), .flag_clr(flag_clr), .irq_flag(irq_flag),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .so(so), .si(si)
    );

    // Vector: {ratio[1:0], tx byte}; loopback transfer returns tx.
    localparam logic [9:0] VEC [0:3] = '{
        {2'd0, 8'hA5}, {2'd1, 8'h3C}, {2'd2, 8'h81}, {2'd3, 8'h6E}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance n edges; return at the following falling edge.
    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic write_mode(logic [3:0] m);
        mode_wdata = m; mode_wr = 1'b1; cyc(1); mode_wr = 1'b0;
    endtask

    task automatic start_xfer();
        start_cmd = 1'b1; cyc(1); start_cmd = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    endtask

    task automatic load(logic [7:0] b);
        data_wdata = b[3:0]; dlo_wr = 1'b1; cyc(1); dlo_wr = 1'b0;
        data_wdata = b[7:4]; dhi_wr = 1'b1; cyc(1); dhi_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; stop_enter = 1'b0; mode_wr = 1'b0; start_cmd = 1'b0;
        dlo_wr = 1'b0; dhi_wr = 1'b0; flag_clr = 1'b0; mode_wdata = 4'h0;
        data_wdata = 4'h0; sck_in = 1'b1; loop_en = 1'b0; si_drv = 1'b0;
        @(negedge clk);
        cyc(3);
        // R1: reset state
        check("R1 irq", irq_flag, 1'b0);
        check("R1 sck_oe", sck_oe, 1'b0);
        check("R1 sck_out", sck_out, 1'b1);
        check("R1 so", so, 1'b1);
        check("R1 data", {data_hi, data_lo}, 8'h00);
        rst_n = 1'b1;
        cyc(1);

        // R3: mode write reaches sck_oe at the second edge
        mode_wdata = 4'b0011; mode_wr = 1'b1; cyc(1); mode_wr = 1'b0;
        check("R3 sck_oe after first edge", sck_oe, 1'b0);
        cyc(1);
        check("R3 sck_oe after second edge", sck_oe, 1'b1);

        // R4/R5/R2: table of internal-clock loopback transfers
        for (int v = 0; v < 4; v++) begin
            logic [1:0] r;
            logic [7:0] tx;
            int         h;
            r  = VEC[v][9:8];
            tx = VEC[v][7:0];
            h  = 2 << r;
            write_mode({r, 2'b11});
            cyc(2);
            clear_flag();
            load(tx);
            loop_en = 1'b1;
            start_xfer();
            cyc(16 * h + 1);
            check("R4 flag not yet", irq_flag, 1'b0);
            cyc(1);
            check("R4 R2 flag due at 16H+2", irq_flag, 1'b1);
            check("R5 loopback data", {data_hi, data_lo}, tx);
            check("R2 clock idles high", sck_out, 1'b1);
        end

        // R12: nibble writes land in their halves while idle
        data_wdata = 4'h5; dlo_wr = 1'b1; cyc(1); dlo_wr = 1'b0;
        check("R12 low nibble", {data_hi, data_lo}, 8'h65);
        data_wdata = 4'hA; dhi_wr = 1'b1; cyc(1); dhi_wr = 1'b0;
        check("R12 high nibble", {data_hi, data_lo}, 8'hA5);

        // R6/R5: external clock, driven bit by bit
        write_mode(4'b0001);
        cyc(2);
        check("R2 sck_oe off for external", sck_oe, 1'b0);
        clear_flag();
        load(8'h96);
        loop_en = 1'b0;
        start_xfer();
        cyc(3);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] tx;
            logic [7:0] rx;
            tx = 8'h96;
            rx = 8'h4B;
            sck_in = 1'b0;
            cyc(4);
            check("R5 so bit LSB first", so, tx[i]);
            si_drv = rx[i];
            sck_in = 1'b1;
            cyc(4);
        end
        check("R6 external completion flag", irq_flag, 1'b1);
        check("R5 R6 received byte", {data_hi, data_lo}, 8'h4B);

        // R6/R12: pin disabled, external clock ignored; writes ignored in transfer
        write_mode(4'b0000);
        cyc(2);
        clear_flag();
        start_xfer();
        cyc(3);
        si_drv = 1'b1;
        for (int i = 0; i < 8; i++) begin
            sck_in = 1'b0; cyc(3); sck_in = 1'b1; cyc(3);
        end
        check("R6 no completion with pin off", irq_flag, 1'b0);
        check("R6 data untouched", {data_hi, data_lo}, 8'h4B);
        data_wdata = 4'hF; dlo_wr = 1'b1; cyc(1); dlo_wr = 1'b0;
        check("R12 write ignored in transfer", data_lo, 4'hB);
        write_mode(4'b0000);
        check("R7 abort with clock high sets flag", irq_flag, 1'b1);

        // R7: abort mid-transfer, then full transfer with reset counter
        write_mode(4'b1111);
        cyc(2);
        clear_flag();
        load(8'h5A);
        loop_en = 1'b1;
        start_xfer();
        cyc(40);
        write_mode(4'b1111);
        check("R7 abort sets flag", irq_flag, 1'b1);
        cyc(40);
        check("R7 clock idle after abort", sck_out, 1'b1);
        clear_flag();
        start_xfer();
        cyc(16 * 16 + 1);
        check("R7 fresh transfer not early", irq_flag, 1'b0);
        cyc(1);
        check("R7 fresh transfer full length", irq_flag, 1'b1);

        // R8: abort in first low phase leaves flag clear
        clear_flag();
        start_xfer();
        cyc(19);
        check("R8 first low phase reached", sck_out, 1'b0);
        write_mode(4'b1111);
        check("R8 no flag at abort", irq_flag, 1'b0);
        cyc(5);
        check("R8 still no flag", irq_flag, 1'b0);
        check("R8 clock back high", sck_out, 1'b1);

        // R9: start during transfer sets flag and restarts
        start_xfer();
        cyc(40);
        start_xfer();
        check("R9 restart sets flag", irq_flag, 1'b1);
        clear_flag();
        cyc(16 * 16);
        check("R9 restarted not early", irq_flag, 1'b0);
        cyc(1);
        check("R9 restarted completes", irq_flag, 1'b1);

        // R10: completion wins over a simultaneous clear
        write_mode(4'b0011);
        cyc(2);
        flag_clr = 1'b1;
        cyc(1);
        check("R10 clear works", irq_flag, 1'b0);
        start_xfer();
        cyc(34);
        check("R10 set wins over clear", irq_flag, 1'b1);
        cyc(1);
        check("R10 clear after", irq_flag, 1'b0);
        flag_clr = 1'b0;

        // R11: stop entry clears mode and idles the unit
        write_mode(4'b1111);
        cyc(2);
        check("R11 sck_oe before stop", sck_oe, 1'b1);
        start_xfer();
        cyc(40);
        stop_enter = 1'b1; cyc(1); stop_enter = 1'b0;
        check("R11 sck_oe cleared", sck_oe, 1'b0);
        check("R11 no flag", irq_flag, 1'b0);
        cyc(5);
        check("R11 clock high", sck_out, 1'b1);
        check("R11 still no flag", irq_flag, 1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule